// File: doc/BRIEF.md
# Multi-Lane Serial Flash Byte Shifter

This block moves one byte per request across a serial flash bus that has up to four data lanes. The host presents a lane mode, a direction, a command flag and a byte, then pulses `start`. The block produces the serial clock, drives the data lanes together with a per-lane output-enable vector, and collects the lanes when receiving. It reports the end of the byte with a one-cycle `done`. Chip-select framing and the ordering of command, address and data bytes belong to the surrounding controller.

A single shifter serves all three lane widths. Width selects 1, 2 or 4 bits per serial clock, and the lane-to-bit mapping is fixed for each width. When the host marks a byte as a command, the width comes from the four-lane command setting and not from the data mode. The parameter `HALF_DIV` sets how many system clocks each serial clock half lasts.

The control FSM has three states. `ST_IDLE` waits for work. `ST_LOW` holds `sck` low while the current bit group is presented. `ST_HIGH` holds `sck` high, and at its end samples the lanes. The transitions are:
- IDLE→LOW when `start` is accepted.
- LOW→HIGH when the half period expires.
- HIGH→LOW at the end of a half period that still has groups left.
- HIGH→IDLE at the end of the last group's half period, which raises `done`.

Top module: `spi_lane_shifter`

## Requirements
- R1: After reset, `sck`=0, `busy`=0, `done`=0 and `rx_byte`=0x00. `lane_out` and `lane_oe` both show the idle pattern 4'b1101: lane 0 is driven high, lane 1 is an input, and lanes 2 and 3 are driven high.
- R2: Every width sends bytes most significant bit first. A byte uses 8 serial clocks in single width, 4 in dual and 2 in quad. `done` rises 2*HALF_DIV*clocks system cycles after the cycle in which `start` is accepted.
- R3: Transmit lane mapping depends on width. In single width the current bit is on lane 0, lane 1 is 0, and lanes 2 and 3 are 1. In dual width the higher bit of each pair is on lane 1 and the lower bit on lane 0, with lanes 2 and 3 at 1. In quad width the first clock carries bits 7..4 on lanes 3..0 and the second clock carries bits 3..0.
- R4: Receive assembles bits MSB first. Single width reads lane 1, dual reads lane 1 as the higher bit and lane 0 as the lower bit, and quad reads lanes 3..0. In a single-width receive, lane 0 is driven 1 and lane 1 is 0, so the byte sent out is all ones.
- R5: Each serial clock spends HALF_DIV system cycles low with its data already presented, then HALF_DIV cycles high. The lanes are sampled at the end of the high half. `sck` is low whenever the block is idle, and `lane_out` does not change while `sck` is high.
- R6: Output enables while busy (bit n for lane n) are: single 4'b1101, dual transmit 4'b1111, dual receive 4'b1100, quad transmit 4'b1111, quad receive 4'b0000. When idle they are 4'b1101.
- R7: When `cmd_phase`=1, the width is quad if `quad_cmd`=1 and single otherwise, whatever `mode` says. When `cmd_phase`=0, `mode` selects the width: 0 is single, 1 is dual, 2 is quad.
- R8: A `start` that arrives while `busy`=1 is ignored. The byte in progress keeps its timing, lane values and result.
- R9: `done` is high for exactly one cycle, the cycle after the last high half, and `busy` is 0 in that cycle. `rx_byte` changes only when `done` rises at the end of a receive. A transmit leaves `rx_byte` unchanged.
- R10: A `mode` value of 3 on a data byte is treated as single width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request to shift one byte |
| mode | input | 2 | Data width: 0 single, 1 dual, 2 quad, 3 single |
| rx_dir | input | 1 | 1 receive, 0 transmit |
| cmd_phase | input | 1 | Byte is a command; width from quad_cmd |
| quad_cmd | input | 1 | Four-lane command mode active |
| tx_byte | input | 8 | Byte to send |
| lane_in | input | 4 | Sampled lane levels |
| sck | output | 1 | Serial clock, idles low |
| lane_out | output | 4 | Driven lane levels |
| lane_oe | output | 4 | Per-lane output enable |
| busy | output | 1 | Byte in progress |
| done | output | 1 | One-cycle end-of-byte pulse |
| rx_byte | output | 8 | Last received byte |

## Verification
The bench drives each lane with the wanted bit and drives the unused lanes with the opposite level. A shifter that read the wrong lane or swapped the two bits of a dual pair would therefore return a different byte. It compares `lane_out` and `lane_oe` on every clock against a model, so a reversed nibble order or a lane left enabled during a quad receive shows up in the cycle it happens. It sends command bytes with the data mode set to dual and to single, which exposes a command width taken from `mode` as a wrong clock count. It also pulses `start` in the middle of a byte: a design that restarts would alter the waveform and finish early.

// File: rtl/spi_lane_pkg.sv
package spi_lane_pkg;

    typedef enum logic [1:0] {
        W_SINGLE = 2'd0,
        W_DUAL   = 2'd1,
        W_QUAD   = 2'd2
    } width_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOW  = 2'd1,
        ST_HIGH = 2'd2
    } phase_e;

    localparam logic [3:0] IDLE_DRIVE = 4'b1101;
    localparam logic [3:0] IDLE_OE    = 4'b1101;

    // Command bytes follow the four-lane command setting; data bytes follow mode.
    function automatic width_e pick_width(logic [1:0] mode, logic is_cmd, logic qcmd);
        width_e w;
        if (is_cmd) begin
            w = qcmd ? W_QUAD : W_SINGLE;
        end else begin
            case (mode)
                2'd1:    w = W_DUAL;
                2'd2:    w = W_QUAD;
                default: w = W_SINGLE;
            endcase
        end
        return w;
    endfunction

    function automatic logic [2:0] last_group(width_e w);
        logic [2:0] n;
        case (w)
            W_DUAL:  n = 3'd3;
            W_QUAD:  n = 3'd1;
            default: n = 3'd7;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/spi_lane_timer.sv
module spi_lane_timer #(
    parameter int HALF_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic half_end
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CW-1:0] TOP = CW'(HALF_DIV - 1);

    logic [CW-1:0] cnt_q;

    assign half_end = run && (cnt_q == TOP);

    always_ff @(posedge clk) begin
        if (!rst_n || !run || half_end) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/spi_lane_map.sv
module spi_lane_map
    import spi_lane_pkg::*;
(
    input  width_e      width,
    input  logic        rx_dir,
    input  logic [7:0]  tx_sr,
    input  logic [7:0]  rx_sr,
    input  logic [3:0]  lane_in,
    output logic [3:0]  drive,
    output logic [3:0]  oe,
    output logic [7:0]  tx_next,
    output logic [7:0]  rx_next
);
    always_comb begin
        drive   = IDLE_DRIVE;
        oe      = IDLE_OE;
        tx_next = tx_sr;
        rx_next = rx_sr;
        unique case (width)
            W_SINGLE: begin
                oe      = 4'b1101;
                drive   = {2'b11, 1'b0, rx_dir ? 1'b1 : tx_sr[7]};
                tx_next = {tx_sr[6:0], 1'b0};
                rx_next = {rx_sr[6:0], lane_in[1]};
            end
            W_DUAL: begin
                oe      = rx_dir ? 4'b1100 : 4'b1111;
                drive   = rx_dir ? 4'b1100 : {2'b11, tx_sr[7], tx_sr[6]};
                tx_next = {tx_sr[5:0], 2'b00};
                rx_next = {rx_sr[5:0], lane_in[1], lane_in[0]};
            end
            W_QUAD: begin
                oe      = rx_dir ? 4'b0000 : 4'b1111;
                drive   = rx_dir ? 4'b0000 : tx_sr[7:4];
                tx_next = {tx_sr[3:0], 4'b0000};
                rx_next = {rx_sr[3:0], lane_in};
            end
            default: begin
                drive = IDLE_DRIVE;
            end
        endcase
    end
endmodule

// File: rtl/spi_lane_shifter.sv
module spi_lane_shifter
    import spi_lane_pkg::*;
#(
    parameter int HALF_DIV = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [1:0] mode,
    input  logic       rx_dir,
    input  logic       cmd_phase,
    input  logic       quad_cmd,
    input  logic [7:0] tx_byte,
    input  logic [3:0] lane_in,
    output logic       sck,
    output logic [3:0] lane_out,
    output logic [3:0] lane_oe,
    output logic       busy,
    output logic       done,
    output logic [7:0] rx_byte
);
    phase_e     state_q, state_d;
    width_e     width_q;
    logic       dir_q;
    logic [7:0] tx_sr_q, rx_sr_q;
    logic [2:0] grp_q;
    logic       done_q;
    logic [7:0] rx_q;

    logic       half_end;
    logic       is_last;
    logic [3:0] map_drive, map_oe;
    logic [7:0] tx_next, rx_next;

    spi_lane_timer #(.HALF_DIV(HALF_DIV)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (state_q != ST_IDLE),
        .half_end (half_end)
    );

    spi_lane_map u_map (
        .width   (width_q),
        .rx_dir  (dir_q),
        .tx_sr   (tx_sr_q),
        .rx_sr   (rx_sr_q),
        .lane_in (lane_in),
        .drive   (map_drive),
        .oe      (map_oe),
        .tx_next (tx_next),
        .rx_next (rx_next)
    );

    assign is_last = (grp_q == last_group(width_q));

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start)    state_d = ST_LOW;
            ST_LOW:  if (half_end) state_d = ST_HIGH;
            ST_HIGH: if (half_end) state_d = is_last ? ST_IDLE : ST_LOW;
            default:               state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // datapath and output registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            width_q <= W_SINGLE;
            dir_q   <= 1'b0;
            tx_sr_q <= '0;
            rx_sr_q <= '0;
            grp_q   <= '0;
            done_q  <= 1'b0;
            rx_q    <= '0;
        end else begin
            done_q <= 1'b0;
            if (state_q == ST_IDLE && start) begin
                width_q <= pick_width(mode, cmd_phase, quad_cmd);
                dir_q   <= rx_dir;
                tx_sr_q <= tx_byte;
                rx_sr_q <= '0;
                grp_q   <= '0;
            end else if (state_q == ST_HIGH && half_end) begin
                tx_sr_q <= tx_next;
                rx_sr_q <= rx_next;
                grp_q   <= grp_q + 3'd1;
                if (is_last) begin
                    done_q <= 1'b1;
                    if (dir_q) rx_q <= rx_next;
                end
            end
        end
    end

    assign busy     = (state_q != ST_IDLE);
    assign sck      = (state_q == ST_HIGH);
    assign lane_out = busy ? map_drive : IDLE_DRIVE;
    assign lane_oe  = busy ? map_oe : IDLE_OE;
    assign done     = done_q;
    assign rx_byte  = rx_q;
endmodule

// File: rtl/spi_lane_shifter_chk.sv
module spi_lane_shifter_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic       sck,
    input logic       busy,
    input logic       done,
    input logic [3:0] lane_out,
    input logic [3:0] lane_oe,
    input logic [7:0] rx_byte
);
    // R5
    sck_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !sck);

    // R5
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sck && $past(sck)) |-> $stable(lane_out));

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R9
    rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!done && $past(rst_n)) |-> $stable(rx_byte));

    // R6
    idle_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (lane_oe == 4'b1101));

    // R8
    accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (busy && !sck));
endmodule

bind spi_lane_shifter spi_lane_shifter_chk chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .sck      (sck),
    .busy     (busy),
    .done     (done),
    .lane_out (lane_out),
    .lane_oe  (lane_oe),
    .rx_byte  (rx_byte)
);

// File: tb/spi_lane_shifter_tb.sv
module spi_lane_shifter_tb_top;
    localparam int H = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [1:0] mode = 2'd0;
    logic       rx_dir = 1'b0;
    logic       cmd_phase = 1'b0;
    logic       quad_cmd = 1'b0;
    logic [7:0] tx_byte = 8'h00;
    logic [3:0] lane_in = 4'h0;
    logic       sck, busy, done;
    logic [3:0] lane_out, lane_oe;
    logic [7:0] rx_byte;

    always #5 clk = ~clk;

    spi_lane_shifter #(.HALF_DIV(H)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .rx_dir(rx_dir),
        .cmd_phase(cmd_phase), .quad_cmd(quad_cmd), .tx_byte(tx_byte),
        .lane_in(lane_in), .sck(sck), .lane_out(lane_out), .lane_oe(lane_oe),
        .busy(busy), .done(done), .rx_byte(rx_byte)
    );

    typedef struct {
        logic       sck, busy, done;
        logic [3:0] out, oe, lin;
        logic [7:0] rx;
    } exp_t;

    exp_t       q[$];
    logic [7:0] rx_planned = 8'h00;
    logic [7:0] rx_pat = 8'h00;
    logic       mon_en = 1'b0;
    int         checks = 0;
    int         errors = 0;
    int         cyc = 0;

    task automatic chk(string tag, int act, int exp, string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h at cycle %0d", tag, what, act, exp, cyc);
        end
    endtask

    function automatic int lanes_of(logic [1:0] m, logic c, logic qc);
        if (c) return qc ? 4 : 1;
        if (m == 2'd1) return 2;
        if (m == 2'd2) return 4;
        return 1;
    endfunction

    // Reference model: expands an accepted byte into per-cycle expectations.
    function automatic void plan(logic [1:0] m, logic d, logic c, logic qc,
                                 logic [7:0] tx, logic [7:0] pat);
        int   ln = lanes_of(m, c, qc);
        int   groups = 8 / ln;
        exp_t e;
        for (int g = 0; g < groups; g++) begin
            for (int k = 0; k < 2 * H; k++) begin
                e.sck  = (k >= H);
                e.busy = 1'b1;
                e.done = 1'b0;
                e.rx   = rx_planned;
                if (ln == 1) begin
                    e.oe  = 4'b1101;
                    e.out = {3'b110, d ? 1'b1 : tx[7-g]};
                    e.lin = {~pat[7-g], ~pat[7-g], pat[7-g], ~pat[7-g]};
                end else if (ln == 2) begin
                    e.oe  = d ? 4'b1100 : 4'b1111;
                    e.out = d ? 4'b1100 : {2'b11, tx[7-2*g], tx[6-2*g]};
                    e.lin = {2'b01, pat[7-2*g], pat[6-2*g]};
                end else begin
                    e.oe  = d ? 4'b0000 : 4'b1111;
                    e.out = d ? 4'b0000 : ((g == 0) ? tx[7:4] : tx[3:0]);
                    e.lin = (g == 0) ? pat[7:4] : pat[3:0];
                end
                q.push_back(e);
            end
        end
        if (d) rx_planned = pat;
        e.sck = 1'b0; e.busy = 1'b0; e.done = 1'b1;
        e.out = 4'b1101; e.oe = 4'b1101; e.lin = 4'hA; e.rx = rx_planned;
        q.push_back(e);
    endfunction

    always @(posedge clk) begin
        cyc++;
        if (rst_n && start && q.size() == 0)
            plan(mode, rx_dir, cmd_phase, quad_cmd, tx_byte, rx_pat);
        if (cyc > 60000) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    always @(negedge clk) begin
        if (mon_en) begin
            exp_t e;
            if (q.size() > 0) begin
                e = q.pop_front();
            end else begin
                e.sck = 1'b0; e.busy = 1'b0; e.done = 1'b0;
                e.out = 4'b1101; e.oe = 4'b1101; e.lin = 4'hA; e.rx = rx_planned;
            end
            chk("R5", sck, e.sck, "sck");
            chk("R2", busy, e.busy, "busy");
            chk("R9", done, e.done, "done");
            chk("R3", lane_out, e.out, "lane_out");
            chk("R6", lane_oe, e.oe, "lane_oe");
            chk("R4", rx_byte, e.rx, "rx_byte");
            lane_in = e.lin;
        end
    end

    task automatic send(logic [1:0] m, logic d, logic c, logic qc,
                        logic [7:0] tx, logic [7:0] pat, bit poke, string tag);
        int n = 0;
        int ln = lanes_of(m, c, qc);
        @(negedge clk); #1;
        mode = m; rx_dir = d; cmd_phase = c; quad_cmd = qc; tx_byte = tx; rx_pat = pat;
        start = 1'b1;
        @(negedge clk); #1;
        start = 1'b0;
        if (poke) begin
            // R8: a second start mid-byte with different settings
            repeat (3) @(negedge clk);
            #1; start = 1'b1; tx_byte = ~tx; rx_dir = ~d; mode = 2'd2;
            @(negedge clk); #1; start = 1'b0;
            n = 4;
        end
        while (!done && n < 200) begin
            @(negedge clk);
            n++;
        end
        // +1 for the negedge already passed before the loop
        chk(tag, n + 1, 2 * H * (8 / ln) + 1, "cycles to done");
        if (d) chk(tag, rx_byte, pat, "received byte");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", sck, 0, "reset sck");
        chk("R1", busy, 0, "reset busy");
        chk("R1", done, 0, "reset done");
        chk("R1", rx_byte, 0, "reset rx_byte");
        chk("R1", lane_out, 4'b1101, "reset lane_out");
        chk("R1", lane_oe, 4'b1101, "reset lane_oe");
        #1 rst_n = 1'b1;
        @(negedge clk);
        mon_en = 1'b1;

        send(2'd0, 1'b0, 1'b0, 1'b0, 8'hA5, 8'h00, 1'b0, "R2");
        send(2'd0, 1'b1, 1'b0, 1'b0, 8'h00, 8'h3C, 1'b0, "R4");
        send(2'd1, 1'b0, 1'b0, 1'b0, 8'hB4, 8'h00, 1'b0, "R3");
        send(2'd1, 1'b1, 1'b0, 1'b0, 8'h00, 8'h96, 1'b0, "R4");
        send(2'd2, 1'b0, 1'b0, 1'b0, 8'h5E, 8'h00, 1'b0, "R3");
        send(2'd2, 1'b1, 1'b0, 1'b0, 8'h00, 8'hC7, 1'b0, "R6");
        send(2'd1, 1'b0, 1'b1, 1'b0, 8'h9F, 8'h00, 1'b0, "R7");
        send(2'd0, 1'b1, 1'b1, 1'b1, 8'h00, 8'h6B, 1'b0, "R7");
        send(2'd3, 1'b1, 1'b0, 1'b0, 8'h00, 8'hE1, 1'b0, "R10");
        send(2'd0, 1'b0, 1'b0, 1'b0, 8'h0F, 8'h00, 1'b0, "R9");
        chk("R9", rx_byte, 8'hE1, "rx_byte after transmit");
        send(2'd1, 1'b1, 1'b0, 1'b0, 8'h00, 8'h2D, 1'b1, "R8");
        send(2'd2, 1'b0, 1'b1, 1'b1, 8'hC3, 8'h00, 1'b0, "R7");

        repeat (5) @(negedge clk);
        chk("R9", q.size(), 0, "model drained");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule